// File: doc/BRIEF.md
# Hierarchical Vertical-Crosswise 4x4 Multiplier

This block multiplies two unsigned 4-bit operands and returns their 8-bit product within a single combinational path. It has no registers and no reset. The product is assembled recursively. Each operand is split into a low half and a high half. Each of the four half pairings goes to a 2x2 vertical-and-crosswise cell. A cell forms four bit products and joins them with exactly two half adders.

An alignment adder combines the four cell results. The two low bits of the low-by-low cell become product bits 1:0 directly. Product bits 7:2 are the sum of the low-by-low cell's upper two bits, both cross cells at weight 2^2, and the high-by-high cell at weight 2^4. All four cells form their bit products at the same time, and summation follows without any sequencing. The block is meant to sit inside a larger datapath, for example ahead of an accumulator, where a register boundary is supplied by the caller.

Top module: `vc_mul4`

## Requirements
- R1: Product bit 0 equals the AND of the two operand bit 0 values.
- R2: When both operands are below 4, the product equals the 2x2 cell result and bits 7:4 are zero. In that result, bit 1 is the XOR of the two cross bit products. Bits 3:2 are the half-adder sum and carry of the high bit product with the carry out of bit 1.
- R3: For all 256 operand pairs, the product equals the unsigned arithmetic product of the operands.
- R4: When either operand is zero, the product is zero.
- R5: Swapping the two operands leaves the product unchanged.
- R6: Product bit 7 can be 1 only when bit 3 of both operands is 1. The largest product is 15*15 = 225 (8'hE1).
- R7: A multiplier of 1, 2, 4 or 8 yields the other operand shifted left by 0, 1, 2 or 3 places.
- R8: The block is purely combinational: a new product appears in the same time step as the operand change, with no clock or reset involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_op | input | 4 | Unsigned multiplicand |
| b_op | input | 4 | Unsigned multiplier |
| prod | output | 8 | Unsigned product a_op*b_op |

## Verification
Whenever the operands settle, the assertions check three things: that each 2x2 cell agrees with a two-bit product, that the final product agrees with a behavioural multiply, and that the zero-operand and top-bit rules hold. These checks sit on internal cell boundaries, so a fault inside one cell is caught at its source. Only the bench's scenarios can show operand symmetry and the shift behaviour for powers of two. The bench also sweeps every operand pair and confirms that results appear without any clock edge.

// File: rtl/vc_mul4.sv
module vc_mul4 (
  input  logic [3:0] a_op,
  input  logic [3:0] b_op,
  output logic [7:0] prod
);

  localparam int HW    = 2;
  localparam int CW    = 2 * HW;
  localparam int NCELL = 4;

  logic [CW-1:0] cell_r [NCELL];
  logic [5:0]    upper;

  for (genvar k = 0; k < NCELL; k++) begin : g_cell
    localparam int AO = (k % 2) * HW;
    localparam int BO = (k / 2) * HW;
    logic [HW-1:0] ca, cb;
    logic          pp00, pp01, pp10, pp11;
    logic          s1, c1, s2, c2;

    assign ca   = a_op[AO +: HW];
    assign cb   = b_op[BO +: HW];
    assign pp00 = ca[0] & cb[0];
    assign pp01 = ca[0] & cb[1];
    assign pp10 = ca[1] & cb[0];
    assign pp11 = ca[1] & cb[1];

    assign s1 = pp01 ^ pp10;
    assign c1 = pp01 & pp10;
    assign s2 = pp11 ^ c1;
    assign c2 = pp11 & c1;

    assign cell_r[k] = {c2, s2, s1, pp00};

    always_comb begin
      // R2
      cell_prod_chk: assert (cell_r[k] == ({2'b00, ca} * {2'b00, cb}))
        else $error("cell %0d mismatch", k);
    end
  end

  // cell 0: low*low, 1: high(a)*low(b), 2: low(a)*high(b), 3: high*high
  assign upper = {4'b0000, cell_r[0][3:2]}
               + {2'b00, cell_r[1]}
               + {2'b00, cell_r[2]}
               + {cell_r[3], 2'b00};

  assign prod = {upper, cell_r[0][1:0]};

  always_comb begin
    // R3
    full_prod_chk: assert (prod == ({4'b0000, a_op} * {4'b0000, b_op}))
      else $error("product mismatch");
    // R4
    zero_operand_chk: assert (!(a_op == 4'd0 || b_op == 4'd0) || prod == 8'd0)
      else $error("zero operand gave nonzero product");
    // R6
    top_bit_chk: assert (!prod[7] || (a_op[3] && b_op[3]))
      else $error("bit 7 set without both top bits");
    // R1
    lsb_chk: assert (prod[0] == (a_op[0] & b_op[0]))
      else $error("lsb mismatch");
  end

endmodule

// File: tb/test_vc_mul4.sv
module test_vc_mul4;

  logic       clk = 1'b0;
  logic [3:0] a_op, b_op;
  logic [7:0] prod;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vc_mul4 i_vc_mul4 (.a_op(a_op), .b_op(b_op), .prod(prod));

  localparam int NV = 12;
  localparam logic [15:0] VEC [NV] = '{
    {4'd0,  4'd0,  8'd0},   {4'd1,  4'd1,  8'd1},
    {4'd3,  4'd3,  8'd9},   {4'd2,  4'd3,  8'd6},
    {4'd15, 4'd15, 8'd225}, {4'd7,  4'd9,  8'd63},
    {4'd10, 4'd5,  8'd50},  {4'd12, 4'd12, 8'd144},
    {4'd8,  4'd8,  8'd64},  {4'd6,  4'd11, 8'd66},
    {4'd13, 4'd14, 8'd182}, {4'd15, 4'd1,  8'd15}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a_op, b_op, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] a, input logic [3:0] b);
    @(negedge clk);
    a_op = a;
    b_op = b;
    #1;
  endtask

  initial begin
    a_op = 4'd0;
    b_op = 4'd0;
    #1;
    chk("R8 idle", prod, 8'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][15:12], VEC[i][11:8]);
      chk("R3 table", prod, VEC[i][7:0]);
    end

    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        apply(4'(a), 4'(b));
        chk("R3 sweep", prod, 8'(a * b));
        chk("R1 lsb", {7'd0, prod[0]}, {7'd0, 1'(a & b & 1)});
        if (a == 0 || b == 0) chk("R4 zero", prod, 8'd0);
        if (a < 4 && b < 4) begin
          logic s1, c1, s2, c2;
          s1 = (a[0] & b[1]) ^ (a[1] & b[0]);
          c1 = (a[0] & b[1]) & (a[1] & b[0]);
          s2 = (a[1] & b[1]) ^ c1;
          c2 = (a[1] & b[1]) & c1;
          chk("R2 cell", prod, {4'd0, c2, s2, s1, 1'(a & b & 1)});
        end
        if (!(a[3] && b[3])) chk("R6 top", {7'd0, prod[7]}, 8'd0);
      end

    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        logic [7:0] fwd;
        apply(4'(a), 4'(b));
        fwd = prod;
        apply(4'(b), 4'(a));
        chk("R5 swap", prod, fwd);
      end

    for (int a = 0; a < 16; a++)
      for (int s = 0; s < 4; s++) begin
        apply(4'(a), 4'(1 << s));
        chk("R7 shift", prod, 8'(a) << s);
      end

    apply(4'd15, 4'd15);
    chk("R6 max", prod, 8'hE1);

    @(negedge clk);
    a_op = 4'd9;
    b_op = 4'd7;
    #0.5;
    chk("R8 same step", prod, 8'd63);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule